// File: doc/BRIEF.md
# Four-slot descriptor ring queue

This block is the per-channel queue pair that sits between a host register port and a DMA engine. The host builds each transfer descriptor by writing four 32-bit words, one after another, to a single data address. A staging register collects the first three words. The fourth word completes the descriptor and stores it whole in one of four ring slots. The engine takes descriptors whole through a valid/ready stream.

A second ring of the same shape carries reports the other way. The engine pushes whole four-word reports through a valid/ready stream. The host drains each report by reading one data address four times.

Each ring has a status word. It shows the 2-bit write slot, the 2-bit read slot, separate full and empty flags, and a sticky error flag. The error flag is raised by an overflow or an underflow and is cleared by writing 1 to its bit. A control bit holds both rings in reset until the host writes it back to 0.

Stream rules: `desc_valid` is high while the descriptor ring holds an entry and the reset bit is clear. A descriptor is taken in a cycle where `desc_valid` and `desc_ready` are both high. While `desc_valid` is high and `desc_ready` is low, `desc_data` holds steady. `rpt_ready` is high while the report ring has a free slot and the reset bit is clear. A report is stored in a cycle where `rpt_valid` and `rpt_ready` are both high. A report offered while `rpt_ready` is low is not taken, and the engine keeps it.

Top module: `dring_channel`

## Requirements
- R1: After `rst_n` is released, both rings are empty with both slots at 0 and errors clear, the control bit reads 0, `desc_valid` is 0 and `rpt_ready` is 1.
- R2: A status word carries the write slot in bits [1:0], the read slot in bits [5:4], empty in bit 8, full in bit 9 and error in bit 10. All other bits are 0. Reading a status word has no side effect.
- R3: Four writes to the descriptor data address form one descriptor. The words land in `desc_data` in order: address low [31:0], address high [63:32], length [95:64], flags [127:96]. The write slot advances only when the fourth word is accepted.
- R4: Descriptors leave in the order they were written. The read slot advances on each `desc_valid && desc_ready` cycle. `desc_data` is stable while `desc_valid` is high and `desc_ready` is low.
- R5: A ring holds exactly four entries. When the two slot indices are equal, the full flag or the empty flag tells 4 entries from 0.
- R6: A word written to the descriptor data address while the descriptor ring is full is dropped and sets that ring's error flag. Stored descriptors and slot indices are unchanged. Fullness is judged at the start of the cycle, so an engine pop in the same cycle does not rescue the word.
- R7: `rpt_ready` is high exactly while the report ring is not full and the reset bit is clear. A handshake stores `rpt_data` in the write slot.
- R8: Reads of the report data address return the head report's words in order: count low [31:0], count high [63:32], auxiliary [95:64], flags [127:96]. Each word appears on `host_rd_data` one cycle after `host_rd_en`. The read slot advances after the fourth word.
- R9: A read of the report data address while the report ring is empty returns 0 and sets the report ring's error flag.
- R10: Writing a status address with bit 10 set clears that ring's error flag. All other written bits are ignored. If an error event falls in the same cycle, the flag stays set.
- R11: Writing 1 to bit 0 of the control address empties both rings and clears the staging word count, the drain word count and both error flags. While the bit is 1, descriptor data writes are ignored, report data reads return 0 without error, `desc_valid` is 0 and `rpt_ready` is 0. Writing 0 releases the reset.
- R12: Completing a descriptor (fourth word) in the same cycle as an engine pop applies both: the write slot and the read slot each advance. An engine report push in the same cycle as the host's fourth drain read likewise applies both.
- R13: The address map is control = 0, descriptor status = 1, descriptor data = 2, report status = 3, report data = 4. Reads of the descriptor data address or of unmapped addresses return 0 with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | 3 | Host write word address |
| host_wr_data | input | 32 | Host write data |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_addr | input | 3 | Host read word address |
| host_rd_data | output | 32 | Read data, valid one cycle after `host_rd_en` |
| desc_valid | output | 1 | A whole descriptor is available to the engine |
| desc_ready | input | 1 | Engine takes the head descriptor |
| desc_data | output | 128 | Head descriptor, four words |
| rpt_valid | input | 1 | Engine offers a report |
| rpt_ready | output | 1 | Report ring can accept a report |
| rpt_data | input | 128 | Offered report, four words |

## Verification
Two pairs of events can fall in the same cycle. On the descriptor ring, the host's fourth word can complete a descriptor while the engine pops another. On the report ring, the engine can push a report while the host reads the last word of the head report. The bench provokes each pair by raising the engine handshake in the same cycle as the host access. It then judges the status word: both slot indices must have advanced, the entry count must be unchanged, and the head data must be the next entry in order. A third collision, an underflow read together with a write-one-to-clear of the same error flag, must leave the flag set.

// File: rtl/dring_pkg.sv
package dring_pkg;
  // host word addresses
  localparam int unsigned ADR_CTRL      = 0;
  localparam int unsigned ADR_DESC_STAT = 1;
  localparam int unsigned ADR_DESC_DATA = 2;
  localparam int unsigned ADR_RPT_STAT  = 3;
  localparam int unsigned ADR_RPT_DATA  = 4;

  // status word fields, decoded by host software
  localparam int ST_WR_LSB = 0;
  localparam int ST_RD_LSB = 4;
  localparam int ST_EMPTY  = 8;
  localparam int ST_FULL   = 9;
  localparam int ST_ERR    = 10;

  // control word
  localparam int CTRL_RST_BIT = 0;
endpackage

// File: rtl/dring_slot_ring.sv
module dring_slot_ring #(
  parameter int ENTRY_W = 128,
  parameter int DEPTH   = 4,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head_data,
  output logic [PTR_W-1:0]   wr_slot,
  output logic [PTR_W-1:0]   rd_slot,
  output logic               full,
  output logic               empty
);
  // one extra wrap bit on each pointer separates full from empty
  logic [PTR_W:0]       wr_q, rd_q;
  logic [ENTRY_W-1:0]   mem [DEPTH];
  logic                 do_push, do_pop;

  assign full    = (wr_q[PTR_W] != rd_q[PTR_W]) && (wr_q[PTR_W-1:0] == rd_q[PTR_W-1:0]);
  assign empty   = (wr_q == rd_q);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  assign wr_slot   = wr_q[PTR_W-1:0];
  assign rd_slot   = rd_q[PTR_W-1:0];
  assign head_data = mem[rd_q[PTR_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (clr) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_q[PTR_W-1:0]] <= push_data;
  end
endmodule

// File: rtl/dring_word_packer.sv
module dring_word_packer #(
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  localparam int ENTRY_W = WORD_W * WORDS,
  localparam int IDX_W   = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               word_valid,
  input  logic [WORD_W-1:0]  word_data,
  input  logic               ring_full,
  output logic               push,
  output logic [ENTRY_W-1:0] entry,
  output logic               overflow
);
  logic [IDX_W-1:0]              idx_q;
  logic [(WORDS-1)*WORD_W-1:0]   stage_q;
  logic                          accept, last;

  assign accept   = word_valid && !ring_full;
  assign overflow = word_valid && ring_full;
  assign last     = (idx_q == IDX_W'(WORDS - 1));
  assign push     = accept && last;

  // the closing word goes straight into the entry beside the staged words
  assign entry = {word_data, stage_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      stage_q <= '0;
    end else if (clr) begin
      idx_q   <= '0;
      stage_q <= '0;
    end else if (accept) begin
      idx_q <= last ? '0 : idx_q + 1'b1;
      for (int i = 0; i < WORDS - 1; i++) begin
        if (idx_q == IDX_W'(i)) stage_q[i*WORD_W +: WORD_W] <= word_data;
      end
    end
  end
endmodule

// File: rtl/dring_word_unpacker.sv
module dring_word_unpacker #(
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  localparam int ENTRY_W = WORD_W * WORDS,
  localparam int IDX_W   = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               rd_req,
  input  logic               empty,
  input  logic [ENTRY_W-1:0] head_data,
  output logic [WORD_W-1:0]  word,
  output logic               pop,
  output logic               underflow
);
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] lanes [WORDS];
  logic              emit, last;

  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    assign lanes[g] = head_data[g*WORD_W +: WORD_W];
  end

  assign emit      = rd_req && !empty;
  assign last      = (idx_q == IDX_W'(WORDS - 1));
  assign pop       = emit && last;
  assign underflow = rd_req && empty;
  assign word      = empty ? '0 : lanes[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (clr)    idx_q <= '0;
    else if (emit)   idx_q <= last ? '0 : idx_q + 1'b1;
  end
endmodule

// File: rtl/dring_err_flag.sv
module dring_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  input  logic w1c,
  output logic flag
);
  // a new error outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (clr)    flag <= 1'b0;
    else if (set)    flag <= 1'b1;
    else if (w1c)    flag <= 1'b0;
  end
endmodule

// File: rtl/dring_channel.sv
module dring_channel
  import dring_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  parameter int DEPTH    = 4,
  parameter int ADDR_W   = 3,
  localparam int ENTRY_W = WORD_W * WORDS,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic [ADDR_W-1:0]  host_wr_addr,
  input  logic [WORD_W-1:0]  host_wr_data,
  input  logic               host_rd_en,
  input  logic [ADDR_W-1:0]  host_rd_addr,
  output logic [WORD_W-1:0]  host_rd_data,
  output logic               desc_valid,
  input  logic               desc_ready,
  output logic [ENTRY_W-1:0] desc_data,
  input  logic               rpt_valid,
  output logic               rpt_ready,
  input  logic [ENTRY_W-1:0] rpt_data
);
  function automatic logic [WORD_W-1:0] pack_status(
    input logic [PTR_W-1:0] wr, input logic [PTR_W-1:0] rd,
    input logic is_empty, input logic is_full, input logic is_err);
    logic [WORD_W-1:0] s;
    s = '0;
    s[ST_WR_LSB +: PTR_W] = wr;
    s[ST_RD_LSB +: PTR_W] = rd;
    s[ST_EMPTY] = is_empty;
    s[ST_FULL]  = is_full;
    s[ST_ERR]   = is_err;
    return s;
  endfunction

  // ---------------- host decode ----------------
  logic ctrl_rst;
  logic wr_ctrl, wr_dstat, wr_ddata, wr_rstat;
  logic rd_rdata;

  assign wr_ctrl  = host_wr_en && (host_wr_addr == ADDR_W'(ADR_CTRL));
  assign wr_dstat = host_wr_en && (host_wr_addr == ADDR_W'(ADR_DESC_STAT));
  assign wr_ddata = host_wr_en && (host_wr_addr == ADDR_W'(ADR_DESC_DATA));
  assign wr_rstat = host_wr_en && (host_wr_addr == ADDR_W'(ADR_RPT_STAT));
  assign rd_rdata = host_rd_en && (host_rd_addr == ADDR_W'(ADR_RPT_DATA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_rst <= 1'b0;
    else if (wr_ctrl) ctrl_rst <= host_wr_data[CTRL_RST_BIT];
  end

  // ---------------- descriptor ring ----------------
  logic               d_push, d_pop, d_full, d_empty, d_ovf, d_err;
  logic [ENTRY_W-1:0] d_entry;
  logic [PTR_W-1:0]   d_wr_ptr, d_rd_ptr;

  dring_word_packer #(.WORD_W(WORD_W), .WORDS(WORDS)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (ctrl_rst),
    .word_valid (wr_ddata && !ctrl_rst),
    .word_data  (host_wr_data),
    .ring_full  (d_full),
    .push       (d_push),
    .entry      (d_entry),
    .overflow   (d_ovf)
  );

  dring_slot_ring #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_desc_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctrl_rst),
    .push      (d_push),
    .push_data (d_entry),
    .pop       (d_pop),
    .head_data (desc_data),
    .wr_slot   (d_wr_ptr),
    .rd_slot   (d_rd_ptr),
    .full      (d_full),
    .empty     (d_empty)
  );

  assign desc_valid = !d_empty && !ctrl_rst;
  assign d_pop      = desc_valid && desc_ready;

  dring_err_flag u_desc_err (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctrl_rst),
    .set   (d_ovf),
    .w1c   (wr_dstat && host_wr_data[ST_ERR]),
    .flag  (d_err)
  );

  // ---------------- report ring ----------------
  logic               r_push, r_pop, r_full, r_empty, r_unf, r_err;
  logic [ENTRY_W-1:0] r_head;
  logic [WORD_W-1:0]  r_word;
  logic [PTR_W-1:0]   r_wr_ptr, r_rd_ptr;

  assign rpt_ready = !r_full && !ctrl_rst;
  assign r_push    = rpt_valid && rpt_ready;

  dring_slot_ring #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_rpt_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctrl_rst),
    .push      (r_push),
    .push_data (rpt_data),
    .pop       (r_pop),
    .head_data (r_head),
    .wr_slot   (r_wr_ptr),
    .rd_slot   (r_rd_ptr),
    .full      (r_full),
    .empty     (r_empty)
  );

  dring_word_unpacker #(.WORD_W(WORD_W), .WORDS(WORDS)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctrl_rst),
    .rd_req    (rd_rdata && !ctrl_rst),
    .empty     (r_empty),
    .head_data (r_head),
    .word      (r_word),
    .pop       (r_pop),
    .underflow (r_unf)
  );

  dring_err_flag u_rpt_err (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctrl_rst),
    .set   (r_unf),
    .w1c   (wr_rstat && host_wr_data[ST_ERR]),
    .flag  (r_err)
  );

  // ---------------- read return ----------------
  logic [WORD_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (host_rd_addr == ADDR_W'(ADR_CTRL)) begin
      rd_next[CTRL_RST_BIT] = ctrl_rst;
    end else if (host_rd_addr == ADDR_W'(ADR_DESC_STAT)) begin
      rd_next = pack_status(d_wr_ptr, d_rd_ptr, d_empty, d_full, d_err);
    end else if (host_rd_addr == ADDR_W'(ADR_RPT_STAT)) begin
      rd_next = pack_status(r_wr_ptr, r_rd_ptr, r_empty, r_full, r_err);
    end else if (host_rd_addr == ADDR_W'(ADR_RPT_DATA)) begin
      rd_next = ctrl_rst ? '0 : r_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          host_rd_data <= '0;
    else if (host_rd_en) host_rd_data <= rd_next;
  end
endmodule

// File: rtl/dring_channel_chk.sv
module dring_channel_chk
  import dring_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  parameter int DEPTH    = 4,
  parameter int ADDR_W   = 3,
  localparam int ENTRY_W = WORD_W * WORDS,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctrl_rst,
  input logic               host_wr_en,
  input logic [ADDR_W-1:0]  host_wr_addr,
  input logic               host_rd_en,
  input logic [ADDR_W-1:0]  host_rd_addr,
  input logic [WORD_W-1:0]  host_rd_data,
  input logic               desc_valid,
  input logic               desc_ready,
  input logic [ENTRY_W-1:0] desc_data,
  input logic               d_full,
  input logic               d_empty,
  input logic               d_err,
  input logic               r_full,
  input logic               r_empty,
  input logic               r_err,
  input logic [PTR_W-1:0]   d_wr_ptr
);
  logic dwr_data, rrd_data;
  assign dwr_data = host_wr_en && (host_wr_addr == ADDR_W'(ADR_DESC_DATA));
  assign rrd_data = host_rd_en && (host_rd_addr == ADDR_W'(ADR_RPT_DATA));

  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_full && d_empty) && !(r_full && r_empty));

  p_desc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || ctrl_rst)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_data));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dwr_data && d_full && !ctrl_rst |=> d_err);

  p_underflow_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rrd_data && r_empty && !ctrl_rst |=> (host_rd_data == '0) && r_err);

  p_wr_slot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rst && !dwr_data |=> $stable(d_wr_ptr));

  p_release_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rst) |-> d_empty && r_empty);
endmodule

bind dring_channel dring_channel_chk #(
  .WORD_W(WORD_W), .WORDS(WORDS), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_rst     (ctrl_rst),
  .host_wr_en   (host_wr_en),
  .host_wr_addr (host_wr_addr),
  .host_rd_en   (host_rd_en),
  .host_rd_addr (host_rd_addr),
  .host_rd_data (host_rd_data),
  .desc_valid   (desc_valid),
  .desc_ready   (desc_ready),
  .desc_data    (desc_data),
  .d_full       (d_full),
  .d_empty      (d_empty),
  .d_err        (d_err),
  .r_full       (r_full),
  .r_empty      (r_empty),
  .r_err        (r_err),
  .d_wr_ptr     (d_wr_ptr)
);

// File: tb/dring_channel_bench.sv
`timescale 1ns/1ps
module dring_channel_bench;
  localparam logic [2:0] A_CTRL = 3'd0, A_DSTAT = 3'd1, A_DDATA = 3'd2,
                         A_RSTAT = 3'd3, A_RDATA = 3'd4, A_NONE = 3'd7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_wr_en = 1'b0;
  logic [2:0]   host_wr_addr = '0;
  logic [31:0]  host_wr_data = '0;
  logic         host_rd_en = 1'b0;
  logic [2:0]   host_rd_addr = '0;
  logic [31:0]  host_rd_data;
  logic         desc_valid;
  logic         desc_ready = 1'b0;
  logic [127:0] desc_data;
  logic         rpt_valid = 1'b0;
  logic         rpt_ready;
  logic [127:0] rpt_data = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dring_channel u_dring_channel (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_data(rpt_data)
  );

  // ---------- helpers ----------
  function automatic logic [31:0] wd(input logic [7:0] tag, input int i);
    return {tag, 8'(i), 16'hC0DE};
  endfunction

  function automatic logic [127:0] ent(input logic [7:0] tag);
    return {wd(tag, 3), wd(tag, 2), wd(tag, 1), wd(tag, 0)};
  endfunction

  function automatic logic [31:0] st(input logic [1:0] wr, input logic [1:0] rd,
                                     input bit e, input bit f, input bit er);
    return {21'b0, er, f, e, 2'b0, rd, 2'b0, wr};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_rd_addr = a;
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rd_data;
  endtask

  task automatic push_desc(input logic [7:0] tag);
    for (int i = 0; i < 4; i++) host_write(A_DDATA, wd(tag, i));
  endtask

  task automatic pop_desc();
    @(negedge clk); desc_ready = 1'b1;
    @(negedge clk); desc_ready = 1'b0;
  endtask

  task automatic push_rpt(input logic [7:0] tag);
    @(negedge clk); rpt_valid = 1'b1; rpt_data = ent(tag);
    @(negedge clk); rpt_valid = 1'b0;
  endtask

  // ---------- scenarios ----------
  task automatic t_reset_state();
    logic [31:0] v;
    host_read(A_DSTAT, v); chk("R1/R2 desc status after reset", v, st(0, 0, 1, 0, 0));
    host_read(A_RSTAT, v); chk("R1/R2 report status after reset", v, st(0, 0, 1, 0, 0));
    host_read(A_CTRL, v);  chk("R1 control after reset", v, 32'h0);
    chk("R1 desc_valid low", 32'(desc_valid), 32'h0);
    chk("R1 rpt_ready high", 32'(rpt_ready), 32'h1);
    host_read(A_NONE, v);  chk("R13 unmapped read", v, 32'h0);
  endtask

  task automatic t_desc_assembly();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) host_write(A_DDATA, wd(8'h01, i));
    host_read(A_DSTAT, v); chk("R3 slot held on partial", v, st(0, 0, 1, 0, 0));
    chk("R3 no valid on partial", 32'(desc_valid), 32'h0);
    host_read(A_DDATA, v); chk("R13 desc data reads 0", v, 32'h0);
    host_write(A_DDATA, wd(8'h01, 3));
    host_read(A_DSTAT, v); chk("R3 slot after fourth word", v, st(1, 0, 0, 0, 0));
    chk("R4 valid with entry", 32'(desc_valid), 32'h1);
    for (int i = 0; i < 4; i++) chk("R3 descriptor word order", desc_data[i*32 +: 32], wd(8'h01, i));
    repeat (3) @(negedge clk);
    chk("R4 data held without ready", desc_data[31:0], wd(8'h01, 0));
    pop_desc();
    host_read(A_DSTAT, v); chk("R4 read slot after pop", v, st(1, 1, 1, 0, 0));
  endtask

  task automatic t_full_overflow();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) push_desc(8'h10 + 8'(k));
    host_read(A_DSTAT, v); chk("R5 full with equal slots", v, st(1, 1, 0, 1, 0));
    host_write(A_DDATA, 32'hDEAD_BEEF);
    host_read(A_DSTAT, v); chk("R6 overflow sets error", v, st(1, 1, 0, 1, 1));
    host_write(A_DSTAT, 32'h0000_03FF);
    host_read(A_DSTAT, v); chk("R10 other bits ignored", v, st(1, 1, 0, 1, 1));
    for (int k = 0; k < 4; k++) begin
      chk("R6 stored word0 intact", desc_data[31:0], wd(8'h10 + 8'(k), 0));
      chk("R4 order flags word", desc_data[127:96], wd(8'h10 + 8'(k), 3));
      pop_desc();
    end
    host_read(A_DSTAT, v); chk("R5 empty with equal slots", v, st(1, 1, 1, 0, 1));
    host_write(A_DSTAT, 32'h0000_0400);
    host_read(A_DSTAT, v); chk("R10 w1c clears error", v, st(1, 1, 1, 0, 0));
  endtask

  task automatic t_desc_concurrent();
    logic [31:0] v;
    push_desc(8'h20); push_desc(8'h21);
    for (int i = 0; i < 3; i++) host_write(A_DDATA, wd(8'h22, i));
    host_read(A_DSTAT, v); chk("R12 before collision", v, st(3, 1, 0, 0, 0));
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_addr = A_DDATA; host_wr_data = wd(8'h22, 3); desc_ready = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0; desc_ready = 1'b0;
    host_read(A_DSTAT, v); chk("R12 push and pop same cycle", v, st(0, 2, 0, 0, 0));
    chk("R12 head after collision", desc_data[31:0], wd(8'h21, 0));
    pop_desc();
    chk("R12 completed descriptor", desc_data[127:96], wd(8'h22, 3));
    pop_desc();
    host_read(A_DSTAT, v); chk("R4 drained", v, st(0, 0, 1, 0, 0));
  endtask

  task automatic t_report_drain();
    logic [31:0] v;
    push_rpt(8'h40); push_rpt(8'h41);
    host_read(A_RSTAT, v); chk("R7 two reports stored", v, st(2, 0, 0, 0, 0));
    for (int i = 0; i < 3; i++) begin
      host_read(A_RDATA, v); chk("R8 report word order", v, wd(8'h40, i));
    end
    host_read(A_RSTAT, v); chk("R8 read slot held mid-entry", v, st(2, 0, 0, 0, 0));
    host_read(A_RDATA, v); chk("R8 report flags word", v, wd(8'h40, 3));
    host_read(A_RSTAT, v); chk("R8 read slot after fourth", v, st(2, 1, 0, 0, 0));
    for (int k = 2; k < 5; k++) push_rpt(8'h40 + 8'(k));
    host_read(A_RSTAT, v); chk("R5 report ring full", v, st(1, 1, 0, 1, 0));
    chk("R7 ready low when full", 32'(rpt_ready), 32'h0);
    for (int k = 1; k < 5; k++) begin
      for (int i = 0; i < 4; i++) begin
        host_read(A_RDATA, v); chk("R8 drain order", v, wd(8'h40 + 8'(k), i));
      end
    end
    host_read(A_RSTAT, v); chk("R8 report ring drained", v, st(1, 1, 1, 0, 0));
    chk("R7 ready high again", 32'(rpt_ready), 32'h1);
  endtask

  task automatic t_report_concurrent();
    logic [31:0] v;
    push_rpt(8'h50);
    for (int i = 0; i < 3; i++) host_read(A_RDATA, v);
    @(negedge clk);
    host_rd_en = 1'b1; host_rd_addr = A_RDATA; rpt_valid = 1'b1; rpt_data = ent(8'h51);
    @(negedge clk);
    host_rd_en = 1'b0; rpt_valid = 1'b0;
    chk("R12 last word during push", host_rd_data, wd(8'h50, 3));
    host_read(A_RSTAT, v); chk("R12 push and drain same cycle", v, st(3, 2, 0, 0, 0));
    for (int i = 0; i < 4; i++) begin
      host_read(A_RDATA, v); chk("R12 report pushed in collision", v, wd(8'h51, i));
    end
  endtask

  task automatic t_underflow();
    logic [31:0] v;
    host_read(A_RDATA, v); chk("R9 empty read returns 0", v, 32'h0);
    host_read(A_RSTAT, v); chk("R9 underflow sets error", v, st(3, 3, 1, 0, 1));
    @(negedge clk);
    host_rd_en = 1'b1; host_rd_addr = A_RDATA;
    host_wr_en = 1'b1; host_wr_addr = A_RSTAT; host_wr_data = 32'h0000_0400;
    @(negedge clk);
    host_rd_en = 1'b0; host_wr_en = 1'b0;
    chk("R9 empty read in collision", host_rd_data, 32'h0);
    host_read(A_RSTAT, v); chk("R10 set wins over clear", v, st(3, 3, 1, 0, 1));
    host_write(A_RSTAT, 32'h0000_0400);
    host_read(A_RSTAT, v); chk("R10 report error cleared", v, st(3, 3, 1, 0, 0));
  endtask

  task automatic t_ring_reset();
    logic [31:0] v;
    host_read(A_RDATA, v);
    push_rpt(8'h60);
    push_desc(8'h70);
    host_write(A_DDATA, wd(8'h71, 0)); host_write(A_DDATA, wd(8'h71, 1));
    host_write(A_CTRL, 32'h1);
    host_read(A_CTRL, v); chk("R11 control bit reads 1", v, 32'h1);
    chk("R11 desc_valid low in reset", 32'(desc_valid), 32'h0);
    chk("R11 rpt_ready low in reset", 32'(rpt_ready), 32'h0);
    host_write(A_DDATA, 32'h1234_5678);
    host_read(A_RDATA, v); chk("R11 data read 0 in reset", v, 32'h0);
    host_read(A_RSTAT, v); chk("R11 report ring cleared", v, st(0, 0, 1, 0, 0));
    host_write(A_CTRL, 32'h0);
    host_read(A_CTRL, v); chk("R11 control released", v, 32'h0);
    host_read(A_DSTAT, v); chk("R11 desc ring cleared", v, st(0, 0, 1, 0, 0));
    chk("R11 rpt_ready after release", 32'(rpt_ready), 32'h1);
    for (int i = 0; i < 3; i++) host_write(A_DDATA, wd(8'h72, i));
    host_read(A_DSTAT, v); chk("R11 staging count cleared", v, st(0, 0, 1, 0, 0));
    host_write(A_DDATA, wd(8'h72, 3));
    host_read(A_DSTAT, v); chk("R11 fresh descriptor stored", v, st(1, 0, 0, 0, 0));
    chk("R11 fresh descriptor word0", desc_data[31:0], wd(8'h72, 0));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_desc_assembly();
    t_full_overflow();
    t_desc_concurrent();
    t_report_drain();
    t_report_concurrent();
    t_underflow();
    t_ring_reset();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end
endmodule